// File: doc/BRIEF.md
# Ringing Frequency Discriminator

This block decides whether activity on a ringing line is a genuine ringing signal before a downstream tone generator is allowed to run. It measures the period of the incoming signal in ticks of a 32 kHz timebase, derived by halving the 64 kHz oscillator clock that drives it. It accepts the signal only when the period lies inside a window chosen by two limit-select pins. Dial pulses, speech bursts and other out-of-band activity therefore never reach the tone generator.

The raw input is asynchronous. It is synchronized, and its rising and falling edges are tracked by two independent period trackers. Whichever tracker first sees a full in-window period turns the ring-enable output on. The output stays on while in-window periods keep arriving. It drops on an out-of-window period, or when the line goes quiet for longer than the longest allowed period. A mode pin bypasses the measurement entirely, so that the input level becomes a plain enable. A synchronous standby/reset input clears everything in both modes.

Top module: `ring_discrim`

## Requirements
- R1: While `rst` is high, `ring_en` is 0 from the next clock edge on, in both modes, and all period state is cleared.
- R2: With `bypass_sel` = 1, `ring_en` follows the level of `ring_in` within four clock cycles, with no period check.
- R3: Periods are counted in ticks of half the clock rate. A signal period of P ticks spans 2P clock cycles.
- R4: With `bypass_sel` = 0, `ring_en` rises only after two same-polarity edges (rising or falling, whichever pair completes first) bound an in-window period. One edge of each polarity is not enough.
- R5: The minimum accepted period is 533 ticks when `hi_sel` = 0 and 1067 ticks when `hi_sel` = 1. Shorter periods are rejected.
- R6: The maximum accepted period is 1600 ticks when `lo_sel` = 0 and 2400 ticks when `lo_sel` = 1. Longer periods are rejected.
- R7: `ring_en` stays 1 for as long as each new same-polarity period is in window.
- R8: An out-of-window period clears `ring_en`. Measurement restarts from that edge, so the next in-window period sets `ring_en` again.
- R9: If a tracker sees no edge for more than its maximum period, its count stops at the maximum plus one, `ring_en` drops without any further edge, and the tracker waits for a fresh first edge.
- R10: The limit pins are sampled at each edge and apply to the period that edge starts. A period already in progress is judged against the limits it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 64 kHz oscillator clock |
| rst | input | 1 | Synchronous active-high standby/reset |
| bypass_sel | input | 1 | 1: input level is a direct enable; 0: period discrimination |
| lo_sel | input | 1 | Lower-frequency limit select (maximum period) |
| hi_sel | input | 1 | Upper-frequency limit select (minimum period) |
| ring_in | input | 1 | Asynchronous ringing input |
| ring_en | output | 1 | Registered ring-enable to the tone generator |

## Verification
The assertions assume that `bypass_sel`, `lo_sel` and `hi_sel` are quasi-static pins that change only between clock edges and never glitch. They also assume that `ring_in` is the only truly asynchronous input. The stimulus drives every input on the falling clock edge and changes the mode pins only while `rst` is held or at points where a period is plainly in progress. The signal waveforms are built from whole tick counts, so the boundary periods of 532/533, 1066/1067, 1600/1601 and 2400 ticks hit exactly the limits under test.

// File: rtl/ring_discrim_pkg.sv
package ring_discrim_pkg;
  // Edge polarity served by one period tracker.
  typedef enum logic {POL_RISE = 1'b0, POL_FALL = 1'b1} pol_e;

  // Verdict a tracker reports in the cycle an edge or a timeout is seen.
  typedef struct packed {
    logic good;
    logic bad;
  } verdict_t;
endpackage

// File: rtl/ring_tick_div.sv
module ring_tick_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || phase == LAST) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/ring_period_trk.sv
module ring_period_trk
  import ring_discrim_pkg::*;
#(
  parameter int MIN_FAST  = 533,
  parameter int MIN_SLOW  = 1067,
  parameter int MAX_SHORT = 1600,
  parameter int MAX_LONG  = 2400,
  parameter int CW        = $clog2(MAX_LONG + 3)
) (
  input  logic     clk,
  input  logic     clr,
  input  logic     tick,
  input  logic     edge_i,
  input  logic     lo_sel,
  input  logic     hi_sel,
  output verdict_t verdict
);
  logic          armed;
  logic [CW-1:0] cnt;
  logic [CW-1:0] min_q;
  logic [CW-1:0] max_q;
  logic [CW-1:0] meas;
  logic          in_win;
  logic          expired;

  // The tick landing in the edge cycle belongs to the period that ends there.
  assign meas    = cnt + CW'(tick);
  assign in_win  = (meas >= min_q) && (meas <= max_q);
  assign expired = armed && (cnt > max_q);

  always_comb begin
    verdict.good = edge_i && armed && in_win;
    verdict.bad  = (edge_i && armed && !in_win) || (!edge_i && expired);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      armed <= 1'b0;
      cnt   <= '0;
      min_q <= CW'(MIN_FAST);
      max_q <= CW'(MAX_SHORT);
    end else if (edge_i) begin
      armed <= 1'b1;
      cnt   <= '0;
      min_q <= hi_sel ? CW'(MIN_SLOW) : CW'(MIN_FAST);
      max_q <= lo_sel ? CW'(MAX_LONG) : CW'(MAX_SHORT);
    end else if (expired) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (clr)
    cnt <= max_q + 1'b1);

  // R10
  lim_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !edge_i |=> $stable(min_q) && $stable(max_q));
endmodule

// File: rtl/ring_discrim.sv
module ring_discrim
  import ring_discrim_pkg::*;
#(
  parameter int TICK_DIV  = 2,
  parameter int SYNC_FF   = 2,
  parameter int MIN_FAST  = 533,
  parameter int MIN_SLOW  = 1067,
  parameter int MAX_SHORT = 1600,
  parameter int MAX_LONG  = 2400
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass_sel,
  input  logic lo_sel,
  input  logic hi_sel,
  input  logic ring_in,
  output logic ring_en
);
  localparam int CW   = $clog2(MAX_LONG + 3);
  localparam int NPOL = 2;

  logic            tick;
  logic            lvl;
  logic [NPOL-1:0] edges;
  verdict_t        verd [NPOL];
  logic [NPOL-1:0] good_v;
  logic [NPOL-1:0] bad_v;
  logic            good_any;
  logic            bad_any;
  logic            trk_clr;
  logic            byp_q;

  ring_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  ring_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ring_in),
    .level(lvl),
    .rise (edges[POL_RISE]),
    .fall (edges[POL_FALL])
  );

  assign trk_clr = rst | bypass_sel;

  generate
    for (genvar p = 0; p < NPOL; p++) begin : g_trk
      ring_period_trk #(
        .MIN_FAST (MIN_FAST),
        .MIN_SLOW (MIN_SLOW),
        .MAX_SHORT(MAX_SHORT),
        .MAX_LONG (MAX_LONG),
        .CW       (CW)
      ) u_trk (
        .clk    (clk),
        .clr    (trk_clr),
        .tick   (tick),
        .edge_i (edges[p]),
        .lo_sel (lo_sel),
        .hi_sel (hi_sel),
        .verdict(verd[p])
      );
      assign good_v[p] = verd[p].good;
      assign bad_v[p]  = verd[p].bad;
    end
  endgenerate

  assign good_any = |good_v;
  assign bad_any  = |bad_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_en <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      byp_q <= bypass_sel;
      if (bypass_sel)    ring_en <= lvl;
      else if (byp_q)    ring_en <= 1'b0;
      else if (bad_any)  ring_en <= 1'b0;
      else if (good_any) ring_en <= 1'b1;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> !ring_en);

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bypass_sel |=> ring_en == $past(lvl));

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ring_en) && !$past(bypass_sel) |-> $past(good_any));
endmodule

// File: tb/ring_discrim_tb.sv
module ring_discrim_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bypass_sel = 1'b0;
  logic lo_sel = 1'b0;
  logic hi_sel = 1'b0;
  logic ring_in = 1'b0;
  logic ring_en;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ring_discrim u_dut (
    .clk       (clk),
    .rst       (rst),
    .bypass_sel(bypass_sel),
    .lo_sel    (lo_sel),
    .hi_sel    (hi_sel),
    .ring_in   (ring_in),
    .ring_en   (ring_en)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ring_en actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // One tick is two clocks.
  task automatic hold(int ticks);
    hold_clk(2 * ticks);
  endtask

  task automatic do_reset();
    @(negedge clk);
    ring_in = 1'b0;
    rst = 1'b1;
    hold_clk(4);
    rst = 1'b0;
    hold_clk(2);
  endtask

  // n cycles of: rise, high hi_t ticks, fall, low lo_t ticks.
  task automatic wave(int hi_t, int lo_t, int n);
    for (int i = 0; i < n; i++) begin
      ring_in = 1'b1; hold(hi_t);
      ring_in = 1'b0; hold(lo_t);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 after reset", ring_en, 1'b0);
    lo_sel = 0; hi_sel = 0;
    wave(500, 500, 1); ring_in = 1'b1; hold_clk(6);
    check("R1 ringing before standby", ring_en, 1'b1);
    rst = 1'b1; hold_clk(2);
    check("R1 standby forces low", ring_en, 1'b0);
    rst = 1'b0;
    ring_in = 1'b0; hold(500); ring_in = 1'b1; hold_clk(6);
    check("R1 counters cleared, one edge is not a cycle", ring_en, 1'b0);
  endtask

  task automatic t_bypass();
    do_reset();
    bypass_sel = 1'b1;
    ring_in = 1'b1; hold_clk(5);
    check("R2 bypass high", ring_en, 1'b1);
    ring_in = 1'b0; hold_clk(5);
    check("R2 bypass low", ring_en, 1'b0);
    ring_in = 1'b1; hold_clk(5);
    rst = 1'b1; hold_clk(2);
    check("R1 standby in bypass", ring_en, 1'b0);
    rst = 1'b0; bypass_sel = 1'b0;
    hold_clk(3);
    check("R2 leaving bypass clears", ring_en, 1'b0);
  endtask

  task automatic t_first_cycle();
    do_reset();
    lo_sel = 0; hi_sel = 0;
    ring_in = 1'b1; hold(500);
    ring_in = 1'b0; hold(500);
    hold_clk(-1 + 1);
    check("R4 one edge of each polarity only", ring_en, 1'b0);
    ring_in = 1'b1; hold_clk(6);
    check("R4 enabled after first full cycle", ring_en, 1'b1);
  endtask

  task automatic t_min();
    do_reset(); lo_sel = 0; hi_sel = 0;
    wave(266, 267, 1); ring_in = 1'b1; hold_clk(6);
    check("R5 R3 533 ticks accepted (hi_sel=0)", ring_en, 1'b1);
    do_reset();
    wave(266, 266, 2); ring_in = 1'b1; hold_clk(6);
    check("R5 R3 532 ticks rejected (hi_sel=0)", ring_en, 1'b0);
    do_reset(); hi_sel = 1;
    wave(533, 533, 2); ring_in = 1'b1; hold_clk(6);
    check("R5 1066 ticks rejected (hi_sel=1)", ring_en, 1'b0);
    do_reset();
    wave(533, 534, 1); ring_in = 1'b1; hold_clk(6);
    check("R5 1067 ticks accepted (hi_sel=1)", ring_en, 1'b1);
    hi_sel = 0;
  endtask

  task automatic t_max();
    do_reset(); lo_sel = 0; hi_sel = 0;
    wave(800, 800, 1); ring_in = 1'b1; hold_clk(6);
    check("R6 R3 1600 ticks accepted (lo_sel=0)", ring_en, 1'b1);
    do_reset();
    wave(801, 800, 1); ring_in = 1'b1; hold_clk(6);
    check("R6 R3 1601 ticks rejected (lo_sel=0)", ring_en, 1'b0);
    do_reset(); lo_sel = 1;
    wave(1200, 1200, 1); ring_in = 1'b1; hold_clk(6);
    check("R6 2400 ticks accepted (lo_sel=1)", ring_en, 1'b1);
    lo_sel = 0;
  endtask

  task automatic t_sustain();
    do_reset(); lo_sel = 0; hi_sel = 0;
    for (int i = 0; i < 4; i++) begin
      ring_in = 1'b1; hold_clk(6);
      if (i > 0) check("R7 held on rising edge", ring_en, 1'b1);
      hold_clk(1000 - 6);
      ring_in = 1'b0; hold_clk(6);
      if (i > 0) check("R7 held on falling edge", ring_en, 1'b1);
      hold_clk(1000 - 6);
    end
  endtask

  task automatic t_restart();
    do_reset(); lo_sel = 0; hi_sel = 0;
    wave(500, 500, 2); ring_in = 1'b1; hold_clk(6);
    check("R8 ringing before bad period", ring_en, 1'b1);
    hold_clk(200 - 6);
    ring_in = 1'b0; hold(100);
    ring_in = 1'b1; hold_clk(6);
    check("R8 200-tick period clears", ring_en, 1'b0);
    hold_clk(200 - 6);
    ring_in = 1'b0; hold_clk(6);
    check("R8 still low after short falling period", ring_en, 1'b0);
    hold_clk(1000 - 6);
    ring_in = 1'b1; hold_clk(6);
    check("R8 re-enabled by next valid period", ring_en, 1'b1);
  endtask

  task automatic t_timeout();
    do_reset(); lo_sel = 0; hi_sel = 0;
    wave(500, 500, 3); ring_in = 1'b1; hold_clk(6);
    check("R9 ringing before silence", ring_en, 1'b1);
    hold(1050);
    check("R9 still on before expiry", ring_en, 1'b1);
    hold(80);
    check("R9 dropped after silence", ring_en, 1'b0);
  endtask

  task automatic t_pinchange();
    do_reset(); lo_sel = 0; hi_sel = 0;
    wave(400, 400, 2); ring_in = 1'b1; hold_clk(6);
    check("R10 ringing at 800 ticks", ring_en, 1'b1);
    hi_sel = 1;
    hold_clk(800 - 6);
    ring_in = 1'b0; hold_clk(6);
    check("R10 falling period keeps old limit", ring_en, 1'b1);
    hold_clk(800 - 6);
    ring_in = 1'b1; hold_clk(6);
    check("R10 rising period keeps old limit", ring_en, 1'b1);
    hold_clk(800 - 6);
    ring_in = 1'b0; hold_clk(6);
    check("R10 new limit rejects 800 ticks", ring_en, 1'b0);
    hi_sel = 0;
  endtask

  initial begin
    hold_clk(4);
    t_reset();
    t_bypass();
    t_first_cycle();
    t_min();
    t_max();
    t_sustain();
    t_restart();
    t_timeout();
    t_pinchange();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule